// File: doc/BRIEF.md
# Prescaled Interval Timer Bank

This block holds three independent up-counters behind a small 32-bit register bus with APB-style setup and access phases. Each counter takes its ticks either straight from the bus clock or through a power-of-two divider. It counts those ticks, and it can work in one of two modes. In free mode it only counts up and wraps. In interval mode it goes back to zero when it has reached a programmed limit and records an interval event. Each event latches into a status flag, which is cleared when it is read. An enable bit lets that flag drive the counter's own interrupt line.

Software programs the divider and the limit while the counter is stopped. A single control write then zeroes the counter and starts it. The handler reads the status register, and that read acknowledges the event.

Top module: `tmr_bank`

## Requirements
- R1: After reset, for every counter, counter control reads 0x21, and clock control, interval, count, status and enable all read 0. All interrupt lines are low.
- R2: Register groups sit at byte offsets 0x00 (clock control), 0x0C (counter control), 0x18 (count), 0x24 (interval), 0x54 (status) and 0x60 (enable). Counter k is at group offset + 4*k, and each counter behaves independently of the others.
- R3: Clock control bit 0 turns the divider on and bits [4:1] hold an exponent E. The counter then advances once every 2^(E+1) bus clocks, so E=15 gives one tick per 65536 clocks. Measured from a restart, after C running clocks the counter has taken floor(C / 2^(E+1)) ticks.
- R4: With clock control bit 0 clear, a running counter advances on every clock.
- R5: Counter control bit 0 set stops the counter, and it holds its value. Clearing the bit without a restart resumes counting from the held value.
- R6: Writing 1 to counter control bit 4 zeroes the counter and the divider phase. The same write may also clear bit 0 to start counting. Bit 4 always reads back 0, while bits 5 and [3:0] read back as written.
- R7: With counter control bit 1 set (interval mode), a tick taken while the count equals the interval register returns the count to 0 and sets status bit 0. An interval of 0 therefore raises an event on every tick. With bit 1 clear, the counter counts up and raises no event.
- R8: A completed bus read of the status register clears it. An event arriving on the clock edge that completes the read is kept.
- R9: A counter's interrupt line is high exactly when its status bit 0 and enable bit 0 are both set. Clearing the enable bit lowers the line without clearing the status.
- R10: The count register is read-only, and a bus write to it leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 8 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during the access phase |
| irq | output | 3 | One interrupt line per counter |

## Verification
The bench aims at the divider extremes. An exponent of 15 is run for one clock short of a full division and then for exactly a full division, so a divider off by one bit or one clock reads 0 and 1 the wrong way round. An interval of 0 is run at full rate while the status register is read repeatedly. A design that dropped an event arriving on the clearing edge would read the status back as 0 the second time. The restart bit is written together with other bits, to catch an implementation that stores it or reads it back as 1. Stop-and-resume without a restart is checked exactly, to catch a counter that loses or gains a tick when it stops, or that restarts from zero. Writes to the count register and masking of the enable bit are observed at the ports, which catches a count that a stray write corrupts and status that masking clears.

// File: rtl/tmr_bank_pkg.sv
package tmr_bank_pkg;

  // group base offsets (bytes); counter k sits at base + CH_STRIDE*k
  localparam int unsigned OFS_CLK = 32'h00;
  localparam int unsigned OFS_CTL = 32'h0C;
  localparam int unsigned OFS_VAL = 32'h18;
  localparam int unsigned OFS_IVL = 32'h24;
  localparam int unsigned OFS_STS = 32'h54;
  localparam int unsigned OFS_IEN = 32'h60;
  localparam int unsigned CH_STRIDE = 4;

  // clock control fields
  localparam int unsigned CLK_PEN_BIT = 0;

  // counter control fields
  localparam int unsigned CTL_STOP_BIT  = 0;
  localparam int unsigned CTL_IVL_BIT   = 1;
  localparam int unsigned CTL_RST_BIT   = 4;
  localparam int unsigned CTL_SPARE_BIT = 5;
  // stored control: {spare, bits[3:0]}; the restart bit is never stored
  localparam int unsigned CTL_W = 5;
  localparam logic [CTL_W-1:0] CTL_RESET_VAL = 5'b1_0001;

  typedef enum logic [2:0] {
    GRP_NONE,
    GRP_CLK,
    GRP_CTL,
    GRP_VAL,
    GRP_IVL,
    GRP_STS,
    GRP_IEN
  } grp_e;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic             pre_en_i,
  input  logic [PRE_W-1:0] pre_exp_i,
  output logic             tick_o
);

  localparam int unsigned PCW = 1 << PRE_W;

  logic [PCW-1:0] pre_q;
  logic [PCW-1:0] pre_d;
  logic [PCW-1:0] div_mask;
  logic           pre_we;

  // divide ratio 2^(E+1): terminal phase is the low E+1 bits all set
  always_comb begin
    div_mask = ~({PCW{1'b1}} << ({1'b0, pre_exp_i} + (PRE_W+1)'(1)));
    tick_o   = run_i && (!pre_en_i || (pre_q == div_mask));
  end

  always_comb begin
    pre_we = restart_i || !pre_en_i || run_i;
    if (restart_i || !pre_en_i) begin
      pre_d = '0;
    end else if (tick_o) begin
      pre_d = '0;
    end else begin
      pre_d = pre_q + PCW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (pre_we) begin
      pre_q <= pre_d;
    end
  end

  // R3
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_en_i && tick_o) |=> (!tick_o || !pre_en_i));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel import tmr_bank_pkg::*; #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned PRE_W = 4,
  parameter int unsigned DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] wdata_i,
  input  logic          wr_clk_i,
  input  logic          wr_ctl_i,
  input  logic          wr_ivl_i,
  input  logic          wr_ien_i,
  input  logic          rd_sts_i,
  output logic [DW-1:0] clk_rd_o,
  output logic [DW-1:0] ctl_rd_o,
  output logic [DW-1:0] val_rd_o,
  output logic [DW-1:0] ivl_rd_o,
  output logic [DW-1:0] sts_rd_o,
  output logic [DW-1:0] ien_rd_o,
  output logic          irq_o
);

  localparam int unsigned CLK_W = PRE_W + 1;

  logic [CLK_W-1:0] clk_q, clk_d;
  logic [CTL_W-1:0] ctl_q, ctl_d;
  logic [CNT_W-1:0] ivl_q, ivl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sts_q, sts_d;
  logic             ien_q, ien_d;
  logic             cnt_we;
  logic             restart;
  logic             running;
  logic             wrap;
  logic             tick;
  logic             evt;

  // ---------------- configuration registers ----------------
  always_comb begin
    clk_d = wdata_i[CLK_W-1:0];
    ctl_d = {wdata_i[CTL_SPARE_BIT], wdata_i[3:0]};
    ivl_d = wdata_i[CNT_W-1:0];
    ien_d = wdata_i[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q <= '0;
      ctl_q <= CTL_RESET_VAL;
      ivl_q <= '0;
      ien_q <= 1'b0;
    end else begin
      if (wr_clk_i) clk_q <= clk_d;
      if (wr_ctl_i) ctl_q <= ctl_d;
      if (wr_ivl_i) ivl_q <= ivl_d;
      if (wr_ien_i) ien_q <= ien_d;
    end
  end

  // ---------------- tick source ----------------
  tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (running),
    .restart_i (restart),
    .pre_en_i  (clk_q[CLK_PEN_BIT]),
    .pre_exp_i (clk_q[PRE_W:1]),
    .tick_o    (tick)
  );

  // ---------------- counter ----------------
  always_comb begin
    restart = wr_ctl_i && wdata_i[CTL_RST_BIT];
    running = !ctl_q[CTL_STOP_BIT];
    wrap    = ctl_q[CTL_IVL_BIT] && (cnt_q == ivl_q);
    evt     = tick && wrap && !restart;
    cnt_we  = restart || tick;
    if (restart || wrap) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_we) begin
      cnt_q <= cnt_d;
    end
  end

  // ---------------- event status ----------------
  always_comb begin
    sts_d = evt || (sts_q && !rd_sts_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= 1'b0;
    end else begin
      sts_q <= sts_d;
    end
  end

  // ---------------- read views and interrupt ----------------
  always_comb begin
    clk_rd_o = DW'(clk_q);
    ctl_rd_o = DW'({ctl_q[CTL_W-1], 1'b0, ctl_q[3:0]});
    val_rd_o = DW'(cnt_q);
    ivl_rd_o = DW'(ivl_q);
    sts_rd_o = DW'(sts_q);
    ien_rd_o = DW'(ien_q);
    irq_o    = sts_q && ien_q;
  end

  // R5
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[CTL_STOP_BIT] && !restart) |=> $stable(cnt_q));

  // R6
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));

  // R4
  free_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q[CTL_STOP_BIT] && !ctl_q[CTL_IVL_BIT] && !clk_q[CLK_PEN_BIT] && !restart)
    |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  // R8
  sts_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> sts_q);

  // R8
  sts_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sts_i && !evt) |=> !sts_q);

endmodule

// File: rtl/tmr_regif.sv
module tmr_regif import tmr_bank_pkg::*; #(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DW     = 32
) (
  input  logic                       wr_en_i,
  input  logic                       rd_en_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [NUM_CH-1:0][DW-1:0]  clk_rd_i,
  input  logic [NUM_CH-1:0][DW-1:0]  ctl_rd_i,
  input  logic [NUM_CH-1:0][DW-1:0]  val_rd_i,
  input  logic [NUM_CH-1:0][DW-1:0]  ivl_rd_i,
  input  logic [NUM_CH-1:0][DW-1:0]  sts_rd_i,
  input  logic [NUM_CH-1:0][DW-1:0]  ien_rd_i,
  output logic [NUM_CH-1:0]          wr_clk_o,
  output logic [NUM_CH-1:0]          wr_ctl_o,
  output logic [NUM_CH-1:0]          wr_ivl_o,
  output logic [NUM_CH-1:0]          wr_ien_o,
  output logic [NUM_CH-1:0]          rd_sts_o,
  output logic [DW-1:0]              rdata_o
);

  localparam int unsigned CH_IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  grp_e             hit_grp;
  logic [CH_IW-1:0] hit_ch;

  always_comb begin
    hit_grp = GRP_NONE;
    hit_ch  = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr_i == ADDR_W'(OFS_CLK + CH_STRIDE * c)) begin hit_grp = GRP_CLK; hit_ch = CH_IW'(c); end
      if (addr_i == ADDR_W'(OFS_CTL + CH_STRIDE * c)) begin hit_grp = GRP_CTL; hit_ch = CH_IW'(c); end
      if (addr_i == ADDR_W'(OFS_VAL + CH_STRIDE * c)) begin hit_grp = GRP_VAL; hit_ch = CH_IW'(c); end
      if (addr_i == ADDR_W'(OFS_IVL + CH_STRIDE * c)) begin hit_grp = GRP_IVL; hit_ch = CH_IW'(c); end
      if (addr_i == ADDR_W'(OFS_STS + CH_STRIDE * c)) begin hit_grp = GRP_STS; hit_ch = CH_IW'(c); end
      if (addr_i == ADDR_W'(OFS_IEN + CH_STRIDE * c)) begin hit_grp = GRP_IEN; hit_ch = CH_IW'(c); end
    end
  end

  // the count group has no write strobe: writes there fall away
  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      wr_clk_o[c] = wr_en_i && (hit_grp == GRP_CLK) && (hit_ch == CH_IW'(c));
      wr_ctl_o[c] = wr_en_i && (hit_grp == GRP_CTL) && (hit_ch == CH_IW'(c));
      wr_ivl_o[c] = wr_en_i && (hit_grp == GRP_IVL) && (hit_ch == CH_IW'(c));
      wr_ien_o[c] = wr_en_i && (hit_grp == GRP_IEN) && (hit_ch == CH_IW'(c));
      rd_sts_o[c] = rd_en_i && (hit_grp == GRP_STS) && (hit_ch == CH_IW'(c));
    end
  end

  always_comb begin
    case (hit_grp)
      GRP_CLK: rdata_o = clk_rd_i[hit_ch];
      GRP_CTL: rdata_o = ctl_rd_i[hit_ch];
      GRP_VAL: rdata_o = val_rd_i[hit_ch];
      GRP_IVL: rdata_o = ivl_rd_i[hit_ch];
      GRP_STS: rdata_o = sts_rd_i[hit_ch];
      GRP_IEN: rdata_o = ien_rd_i[hit_ch];
      default: rdata_o = '0;
    endcase
  end

  // R2
  strobe_onehot_chk: assert final ($onehot0({wr_clk_o, wr_ctl_o, wr_ivl_o, wr_ien_o, rd_sts_o}));

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank import tmr_bank_pkg::*; #(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned PRE_W  = 4,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DW-1:0]     pwdata,
  output logic [DW-1:0]     prdata,
  output logic [NUM_CH-1:0] irq
);

  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  logic       wr_en;
  logic       rd_en;

  logic [NUM_CH-1:0][DW-1:0] clk_rd, ctl_rd, val_rd, ivl_rd, sts_rd, ien_rd;
  logic [NUM_CH-1:0]         wr_clk, wr_ctl, wr_ivl, wr_ien, rd_sts;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  always_comb begin
    rst_n_int = rst_sync_q[1];
    wr_en     = psel && penable && pwrite;
    rd_en     = psel && penable && !pwrite;
  end

  tmr_regif #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DW(DW)) u_regif (
    .wr_en_i  (wr_en),
    .rd_en_i  (rd_en),
    .addr_i   (paddr),
    .clk_rd_i (clk_rd),
    .ctl_rd_i (ctl_rd),
    .val_rd_i (val_rd),
    .ivl_rd_i (ivl_rd),
    .sts_rd_i (sts_rd),
    .ien_rd_i (ien_rd),
    .wr_clk_o (wr_clk),
    .wr_ctl_o (wr_ctl),
    .wr_ivl_o (wr_ivl),
    .wr_ien_o (wr_ien),
    .rd_sts_o (rd_sts),
    .rdata_o  (prdata)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    tmr_channel #(.CNT_W(CNT_W), .PRE_W(PRE_W), .DW(DW)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n_int),
      .wdata_i  (pwdata),
      .wr_clk_i (wr_clk[g]),
      .wr_ctl_i (wr_ctl[g]),
      .wr_ivl_i (wr_ivl[g]),
      .wr_ien_i (wr_ien[g]),
      .rd_sts_i (rd_sts[g]),
      .clk_rd_o (clk_rd[g]),
      .ctl_rd_o (ctl_rd[g]),
      .val_rd_o (val_rd[g]),
      .ivl_rd_o (ivl_rd[g]),
      .sts_rd_o (sts_rd[g]),
      .ien_rd_o (ien_rd[g]),
      .irq_o    (irq[g])
    );
  end

endmodule

// File: tb/tmr_bank_tb_top.sv
`timescale 1ns/1ps
module tmr_bank_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        psel, penable, pwrite;
  logic [7:0]  paddr;
  logic [31:0] pwdata;
  logic [31:0] prdata;
  logic [2:0]  irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  localparam int A_CLK = 'h00, A_CTL = 'h0C, A_VAL = 'h18;
  localparam int A_IVL = 'h24, A_STS = 'h54, A_IEN = 'h60;

  typedef struct packed {
    logic        pen;
    logic [3:0]  ex;
    logic [31:0] ivl;
    logic        imode;
    int          wt;
    logic [31:0] exp_cnt;
    logic        exp_sts;
  } vec_t;

  // running clocks per vector = wt + 2 (see enable/stop write timing)
  localparam vec_t VECS [8] = '{
    '{1'b0, 4'd0,  32'd0,   1'b0, 8,     32'd10, 1'b0},
    '{1'b0, 4'd0,  32'd3,   1'b1, 8,     32'd2,  1'b1},
    '{1'b1, 4'd0,  32'd100, 1'b1, 18,    32'd10, 1'b0},
    '{1'b1, 4'd2,  32'd2,   1'b1, 48,    32'd0,  1'b1},
    '{1'b0, 4'd0,  32'd0,   1'b1, 3,     32'd0,  1'b1},
    '{1'b1, 4'd3,  32'd0,   1'b0, 62,    32'd4,  1'b0},
    '{1'b1, 4'd15, 32'd0,   1'b0, 65533, 32'd0,  1'b0},
    '{1'b1, 4'd15, 32'd0,   1'b0, 65534, 32'd1,  1'b0}
  };

  tmr_bank dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .pwdata  (pwdata),
    .prdata  (prdata),
    .irq     (irq)
  );

  always #2 clk = ~clk;

  function automatic logic [7:0] ra(input int grp, input int ch);
    return 8'(grp + 4 * ch);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1'b1;
    @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk); penable = 1'b1;
    #1 d = prdata;
    @(negedge clk); psel = 1'b0; penable = 1'b0;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] held;
    rst_n = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    paddr = '0; pwdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset values on every counter
    chk("R1 irq after reset", {29'b0, irq}, 32'h0);
    for (int ch = 0; ch < 3; ch++) begin
      bus_rd(ra(A_CTL, ch), rd); chk($sformatf("R1 ch%0d ctl", ch), rd, 32'h21);
      bus_rd(ra(A_CLK, ch), rd); chk($sformatf("R1 ch%0d clk", ch), rd, 32'h0);
      bus_rd(ra(A_VAL, ch), rd); chk($sformatf("R1 ch%0d count", ch), rd, 32'h0);
      bus_rd(ra(A_IVL, ch), rd); chk($sformatf("R1 ch%0d interval", ch), rd, 32'h0);
      bus_rd(ra(A_STS, ch), rd); chk($sformatf("R1 ch%0d status", ch), rd, 32'h0);
      bus_rd(ra(A_IEN, ch), rd); chk($sformatf("R1 ch%0d enable", ch), rd, 32'h0);
    end

    // vector table: R2 map, R3 divider, R4 undivided, R7 interval, R9 line
    for (int i = 0; i < 8; i++) begin
      int ch;
      ch = i % 3;
      bus_wr(ra(A_CTL, ch), 32'h1);
      bus_wr(ra(A_CLK, ch), {27'b0, VECS[i].ex, VECS[i].pen});
      bus_wr(ra(A_IVL, ch), VECS[i].ivl);
      bus_wr(ra(A_IEN, ch), 32'h1);
      bus_rd(ra(A_STS, ch), rd);
      bus_wr(ra(A_CTL, ch), {27'b0, 1'b1, 2'b00, VECS[i].imode, 1'b0});
      repeat (VECS[i].wt) @(negedge clk);
      bus_wr(ra(A_CTL, ch), {30'b0, VECS[i].imode, 1'b1});
      chk($sformatf("R9 vec%0d irq", i), {31'b0, irq[ch]}, {31'b0, VECS[i].exp_sts});
      bus_rd(ra(A_VAL, ch), rd);
      chk($sformatf("R2 R3 R4 R7 vec%0d count", i), rd, VECS[i].exp_cnt);
      bus_rd(ra(A_STS, ch), rd);
      chk($sformatf("R7 vec%0d status", i), rd, {31'b0, VECS[i].exp_sts});
    end

    // R5: stop holds, resume continues without restart
    bus_wr(ra(A_CLK, 0), 32'h0);
    bus_wr(ra(A_CTL, 0), 32'h10);
    repeat (5) @(negedge clk);
    bus_wr(ra(A_CTL, 0), 32'h1);
    bus_rd(ra(A_VAL, 0), held);
    chk("R5 R6 count after start and stop", held, 32'd7);
    repeat (20) @(negedge clk);
    bus_rd(ra(A_VAL, 0), rd);
    chk("R5 stopped count held", rd, 32'd7);
    bus_wr(ra(A_CTL, 0), 32'h0);
    repeat (3) @(negedge clk);
    bus_wr(ra(A_CTL, 0), 32'h1);
    bus_rd(ra(A_VAL, 0), rd);
    chk("R5 resume from held value", rd, 32'd12);

    // R10: count register ignores writes
    bus_wr(ra(A_VAL, 0), 32'hDEAD);
    bus_rd(ra(A_VAL, 0), rd);
    chk("R10 count write ignored", rd, 32'd12);

    // R6: restart bit reads back 0 and zeroes the count
    bus_wr(ra(A_CTL, 1), 32'h33);
    bus_rd(ra(A_CTL, 1), rd);
    chk("R6 restart bit reads 0", rd, 32'h23);
    bus_rd(ra(A_VAL, 1), rd);
    chk("R6 restart zeroes count", rd, 32'h0);

    // R8: interval 0 at full rate; event on the clearing edge survives
    bus_wr(ra(A_CLK, 2), 32'h0);
    bus_wr(ra(A_IVL, 2), 32'h0);
    bus_wr(ra(A_CTL, 2), 32'h12);
    bus_rd(ra(A_STS, 2), rd);
    chk("R7 interval zero sets status", rd, 32'h1);
    bus_rd(ra(A_STS, 2), rd);
    chk("R8 concurrent event kept", rd, 32'h1);
    bus_wr(ra(A_CTL, 2), 32'h3);
    bus_rd(ra(A_STS, 2), rd);
    chk("R8 status before clear", rd, 32'h1);
    bus_rd(ra(A_STS, 2), rd);
    chk("R8 status cleared by read", rd, 32'h0);

    // R9: enable masks the line without touching status
    bus_wr(ra(A_IEN, 1), 32'h0);
    bus_wr(ra(A_CLK, 1), 32'h0);
    bus_wr(ra(A_IVL, 1), 32'h0);
    bus_wr(ra(A_CTL, 1), 32'h12);
    bus_wr(ra(A_CTL, 1), 32'h3);
    chk("R9 masked line low", {31'b0, irq[1]}, 32'h0);
    bus_wr(ra(A_IEN, 1), 32'h1);
    chk("R9 unmasked line high", {31'b0, irq[1]}, 32'h1);
    bus_wr(ra(A_IEN, 1), 32'h0);
    chk("R9 remasked line low", {31'b0, irq[1]}, 32'h0);
    bus_rd(ra(A_STS, 1), rd);
    chk("R9 status kept while masked", rd, 32'h1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule